// File: doc/BRIEF.md
# Safety Fault Collection and Reaction Hub

This block is the single gathering point for the error flags of a device's safety mechanisms, such as a lockstep comparator, memory error correction, clock supervisors and supply monitors. Each fault line is level-sensitive. A per-source setting chooses one of three reactions: ignore the line, raise an alarm that escalates after a programmable delay, or enter the safe state at once. A hardware state machine sequences the reaction without processor help. It has four states: NORMAL, CONFIG, ALARM and FAULT.

The transitions are as follows. NORMAL goes to CONFIG on the unlock key pair. CONFIG goes back to NORMAL on the lock key. NORMAL goes to ALARM when an alarm-enabled fault is latched. ALARM goes back to NORMAL on the clear key. ALARM goes to FAULT when the alarm delay expires. Any of NORMAL, CONFIG and ALARM goes to FAULT on a critical fault, which is an immediate-class source or a configuration parity mismatch. FAULT is left only by reset.

A supervisor that cannot be configured times the safe-state reaction. If the reaction-done flag does not arrive within 64 cycles of entering FAULT, the supervisor requests a device reset. Two external pins tell an outside monitor whether the hub is healthy. While healthy they toggle in opposite phase. In FAULT they are held at the same level.

Top module: `fault_hub`

## Requirements
- R1: After reset the hub is in NORMAL with `irq` low, `rst_req` low, `err_pin_a` low and `err_pin_b` high.
- R2: Outside FAULT, `err_pin_a` and `err_pin_b` are always complementary, and both invert every PIN_HALF cycles. With PIN_HALF=4, `err_pin_a` is high after clock edges 4..7, 12..15 and so on, counting from reset release. In FAULT both pins are low.
- R3: CONFIG is entered from NORMAL only by a write of 16'h5A5A to address 0 followed by a write of 16'hA5A5 to address 0. Any other configuration write between the two cancels the sequence.
- R4: Writes to address 1 (alarm enable mask, bit i = source i), address 2 (immediate mask, bit i = source i) and address 3 (alarm delay, bits 7:0) take effect only in CONFIG. In any other state they are ignored.
- R5: A write of 16'h0F0F to address 0 in CONFIG returns the hub to NORMAL.
- R6: A fault on a source whose alarm-enable bit is set is latched. From NORMAL it raises ALARM (`irq` high) at the same clock edge that samples the fault. In CONFIG the latched fault waits until the hub returns to NORMAL. Sources with neither bit set have no effect.
- R7: An uncleared ALARM lasts exactly D+1 cycles, where D is the alarm delay, and then becomes FAULT with `irq` low.
- R8: A write of 16'hC1EA to address 0 outside FAULT clears all latched alarms and returns ALARM to NORMAL. A fault line that is still high latches again on the next edge.
- R9: A fault on a source whose immediate bit is set moves NORMAL, CONFIG or ALARM to FAULT at the edge that samples it.
- R10: Every configuration register carries even parity that is checked every cycle. A write with data bit 15 set stores inverted parity. The resulting mismatch moves the hub to FAULT one edge after that write.
- R11: If `react_done` is high in any of the first 64 cycles spent in FAULT, `rst_req` never rises. Otherwise `rst_req` goes high in the 65th FAULT cycle and stays high.
- R12: FAULT persists until reset. Key writes, register writes and clear writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_in | input | N_SRC | Level fault flags from the safety mechanisms |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 key, 1 alarm mask, 2 immediate mask, 3 delay) |
| cfg_wdata | input | 16 | Configuration write data; bit 15 injects a parity error |
| react_done | input | 1 | Safe-state reaction has completed |
| rst_req | output | 1 | Device reset request from the reaction supervisor |
| irq | output | 1 | High while in ALARM |
| err_pin_a | output | 1 | External status pin, healthy phase A |
| err_pin_b | output | 1 | External status pin, healthy phase B |

## Verification
The hardest path to reach from the ports is the parity-mismatch escalation. Every legal write stores consistent parity, so the mismatch can never occur by chance. The stimulus unlocks the hub and writes each of the three registers with the injection bit set. It then checks that the pins stay healthy for one cycle and go static on the next. The supervisor boundary is also narrow. The bench enters FAULT through an immediate source and places a single-cycle `react_done` pulse at FAULT cycles 0, 20, 63 and 64, and also runs a case with no pulse at all. This separates the last cycle that still counts as in time from the first cycle that does not.

// File: rtl/fault_hub_pkg.sv
package fault_hub_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_CONFIG = 2'd1,
        ST_ALARM  = 2'd2,
        ST_FAULT  = 2'd3
    } hub_state_e;

    localparam logic [15:0] KEY_OPEN_A = 16'h5A5A;
    localparam logic [15:0] KEY_OPEN_B = 16'hA5A5;
    localparam logic [15:0] KEY_SHUT   = 16'h0F0F;
    localparam logic [15:0] KEY_CLEAR  = 16'hC1EA;

    localparam logic [1:0] ADR_KEY = 2'd0;
    localparam logic [1:0] ADR_ENA = 2'd1;
    localparam logic [1:0] ADR_IMM = 2'd2;
    localparam logic [1:0] ADR_DLY = 2'd3;

    localparam int INJ_BIT   = 15;
    // fixed reaction window, deliberately not a parameter
    localparam int SUP_LIMIT = 64;

endpackage

// File: rtl/fault_hub_preg.sv
module fault_hub_preg #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         inj,
    output logic [W-1:0] q,
    output logic         bad
);
    logic par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= RST_VAL;
            par_q <= ^RST_VAL;
        end else if (wr) begin
            q     <= din;
            par_q <= (^din) ^ inj;
        end
    end

    // even parity over data plus stored bit, checked every cycle
    assign bad = (^q) ^ par_q;
endmodule

// File: rtl/fault_hub_cfg.sv
module fault_hub_cfg
    import fault_hub_pkg::*;
#(
    parameter int               N_SRC   = 4,
    parameter int               TMO_W   = 8,
    parameter logic [TMO_W-1:0] TMO_RST = 8'd15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [15:0]      wdata,
    input  hub_state_e       st,
    output logic [N_SRC-1:0] ena,
    output logic [N_SRC-1:0] imm,
    output logic [TMO_W-1:0] dly,
    output logic             open_req,
    output logic             shut_req,
    output logic             clr_req,
    output logic             par_err
);
    logic wr_ok;
    logic armed_q;
    logic bad_ena, bad_imm, bad_dly;
    logic key_wr;

    assign wr_ok  = we && (st == ST_CONFIG);
    assign key_wr = we && (addr == ADR_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (we) begin
            armed_q <= (addr == ADR_KEY) && (wdata == KEY_OPEN_A) && (st == ST_NORMAL);
        end
    end

    assign open_req = key_wr && armed_q && (wdata == KEY_OPEN_B) && (st == ST_NORMAL);
    assign shut_req = key_wr && (wdata == KEY_SHUT)  && (st == ST_CONFIG);
    assign clr_req  = key_wr && (wdata == KEY_CLEAR) && (st != ST_FAULT);

    fault_hub_preg #(.W(N_SRC), .RST_VAL('0)) u_ena (
        .clk(clk), .rst_n(rst_n), .wr(wr_ok && addr == ADR_ENA),
        .din(wdata[N_SRC-1:0]), .inj(wdata[INJ_BIT]), .q(ena), .bad(bad_ena)
    );

    fault_hub_preg #(.W(N_SRC), .RST_VAL('0)) u_imm (
        .clk(clk), .rst_n(rst_n), .wr(wr_ok && addr == ADR_IMM),
        .din(wdata[N_SRC-1:0]), .inj(wdata[INJ_BIT]), .q(imm), .bad(bad_imm)
    );

    fault_hub_preg #(.W(TMO_W), .RST_VAL(TMO_RST)) u_dly (
        .clk(clk), .rst_n(rst_n), .wr(wr_ok && addr == ADR_DLY),
        .din(wdata[TMO_W-1:0]), .inj(wdata[INJ_BIT]), .q(dly), .bad(bad_dly)
    );

    assign par_err = bad_ena | bad_imm | bad_dly;

    // R4
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_CONFIG) |=> $stable({ena, imm, dly}));
endmodule

// File: rtl/fault_hub_sup.sv
module fault_hub_sup
    import fault_hub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_fault,
    input  logic react_done,
    output logic rst_req
);
    localparam int            CW  = $clog2(SUP_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(SUP_LIMIT);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!in_fault) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q && cnt_q != LIM) begin
            if (react_done) done_q <= 1'b1;
            else            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign rst_req = in_fault && (cnt_q == LIM);

    // R11
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R11
    done_in_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fault && react_done && !rst_req) |=> !rst_req);
endmodule

// File: rtl/fault_hub_pins.sv
module fault_hub_pins #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_fault,
    output logic pin_a,
    output logic pin_b
);
    localparam int            DW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DLAST = DW'(HALF - 1);

    logic [DW-1:0] div_q;
    logic          ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ph_q  <= 1'b0;
        end else if (div_q == DLAST) begin
            div_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign pin_a = !in_fault &  ph_q;
    assign pin_b = !in_fault & ~ph_q;

    // R2
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != DLAST) |=> $stable(ph_q));
endmodule

// File: rtl/fault_hub.sv
module fault_hub
    import fault_hub_pkg::*;
#(
    parameter int               N_SRC    = 4,
    parameter int               TMO_W    = 8,
    parameter logic [TMO_W-1:0] TMO_RST  = 8'd15,
    parameter int               PIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] fault_in,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [15:0]      cfg_wdata,
    input  logic             react_done,
    output logic             rst_req,
    output logic             irq,
    output logic             err_pin_a,
    output logic             err_pin_b
);
    hub_state_e       st_q, st_nx;
    logic [N_SRC-1:0] ena, imm, pend_q;
    logic [TMO_W-1:0] dly, alm_q;
    logic             open_req, shut_req, clr_req, par_err;
    logic             crit, alarm_hit, in_fault;

    fault_hub_cfg #(.N_SRC(N_SRC), .TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .st(st_q), .ena(ena), .imm(imm), .dly(dly), .open_req(open_req),
        .shut_req(shut_req), .clr_req(clr_req), .par_err(par_err)
    );

    assign crit      = par_err | (|(fault_in & imm));
    assign alarm_hit = |(pend_q | (fault_in & ena));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= '0;
        else if (clr_req) pend_q <= '0;
        else              pend_q <= pend_q | (fault_in & ena);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 alm_q <= '0;
        else if (st_q != ST_ALARM)  alm_q <= '0;
        else                        alm_q <= alm_q + 1'b1;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_NORMAL: begin
                if (crit)           st_nx = ST_FAULT;
                else if (clr_req)   st_nx = ST_NORMAL;
                else if (alarm_hit) st_nx = ST_ALARM;
                else if (open_req)  st_nx = ST_CONFIG;
            end
            ST_CONFIG: begin
                if (crit)          st_nx = ST_FAULT;
                else if (shut_req) st_nx = ST_NORMAL;
            end
            ST_ALARM: begin
                if (crit)              st_nx = ST_FAULT;
                else if (clr_req)      st_nx = ST_NORMAL;
                else if (alm_q == dly) st_nx = ST_FAULT;
            end
            ST_FAULT: st_nx = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_NORMAL;
        else        st_q <= st_nx;
    end

    always_comb begin
        irq      = (st_q == ST_ALARM);
        in_fault = (st_q == ST_FAULT);
    end

    fault_hub_sup u_sup (
        .clk(clk), .rst_n(rst_n), .in_fault(in_fault),
        .react_done(react_done), .rst_req(rst_req)
    );

    fault_hub_pins #(.HALF(PIN_HALF)) u_pins (
        .clk(clk), .rst_n(rst_n), .in_fault(in_fault),
        .pin_a(err_pin_a), .pin_b(err_pin_b)
    );

    // R12
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAULT) |=> (st_q == ST_FAULT));

    // R6
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|pend_q) || $past(|(fault_in & ena))));

    // R7
    alarm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALARM) |-> (alm_q <= dly));
endmodule

// File: tb/test_fault_hub.sv
`timescale 1ns/1ps
module test_fault_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        react_done = 1'b0;
    logic        rst_req, irq, err_pin_a, err_pin_b;

    int total = 0;
    int bad = 0;
    int dly_set[5] = '{0, 1, 2, 5, 9};
    int done_at[5] = '{0, 20, 63, 64, -1};

    always #2 clk = ~clk;

    fault_hub i_fault_hub (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .react_done(react_done),
        .rst_req(rst_req), .irq(irq), .err_pin_a(err_pin_a), .err_pin_b(err_pin_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        fault_in = '0; cfg_we = 1'b0; react_done = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd0, 16'h5A5A);
        wr(2'd0, 16'hA5A5);
    endtask

    task automatic setup(input logic [3:0] e, input logic [3:0] m, input logic [7:0] d);
        do_reset();
        unlock();
        wr(2'd1, {12'd0, e});
        wr(2'd2, {12'd0, m});
        wr(2'd3, {8'd0, d});
        wr(2'd0, 16'h0F0F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 irq", irq, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 pin_a", err_pin_a, 0);
        check("R1 pin_b", err_pin_b, 1);

        // R2 pin toggling from reset release
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            check("R2 pin_a phase", err_pin_a, (k / 4) % 2);
            check("R2 pin_b phase", err_pin_b, 1 - (k / 4) % 2);
        end

        // R3/R4 interrupted key sequence leaves registers locked
        do_reset();
        wr(2'd0, 16'h5A5A);
        wr(2'd1, 16'h000F);
        wr(2'd0, 16'hA5A5);
        wr(2'd1, 16'h000F);
        wr(2'd0, 16'h0F0F);
        fault_in = 4'hF;
        repeat (3) @(negedge clk);
        check("R3 cancelled unlock no irq", irq, 0);
        check("R4 locked write ignored pins healthy", err_pin_a ^ err_pin_b, 1);
        fault_in = '0;

        // R3/R5/R6 alarm latched in CONFIG waits for lock
        do_reset();
        unlock();
        wr(2'd1, 16'h0001);
        fault_in = 4'h1;
        repeat (3) @(negedge clk);
        check("R6 no alarm in CONFIG", irq, 0);
        wr(2'd0, 16'h0F0F);
        check("R5 lock edge", irq, 0);
        @(negedge clk);
        check("R5 alarm after lock", irq, 1);
        fault_in = '0;

        // R6/R7 alarm length sweep over sources and delays
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 5; t++) begin
                int cnt;
                setup(4'(1 << s), 4'h0, 8'(dly_set[t]));
                fault_in = ~4'(1 << s);
                repeat (3) @(negedge clk);
                check("R6 masked sources ignored", irq, 0);
                fault_in = 4'(1 << s);
                cnt = 0;
                for (int g = 0; g < 400; g++) begin
                    @(negedge clk);
                    if (irq) cnt++;
                    else if (cnt > 0) break;
                end
                check("R7 alarm cycles", cnt, dly_set[t] + 1);
                check("R7 fault pin_a", err_pin_a, 0);
                check("R7 fault pin_b", err_pin_b, 0);
            end
        end

        // R8 clear
        setup(4'h1, 4'h0, 8'd100);
        fault_in = 4'h1;
        repeat (3) @(negedge clk);
        fault_in = '0;
        wr(2'd0, 16'hC1EA);
        check("R8 clear leaves ALARM", irq, 0);
        repeat (5) @(negedge clk);
        check("R8 stays NORMAL", irq, 0);
        fault_in = 4'h1;
        @(negedge clk);
        check("R8 re-alarm", irq, 1);
        wr(2'd0, 16'hC1EA);
        check("R8 clear with fault high", irq, 0);
        @(negedge clk);
        check("R8 relatch next edge", irq, 1);
        fault_in = '0;

        // R9 immediate sources from each non-fault state (0 NORMAL,1 CONFIG,2 ALARM)
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 3; p++) begin
                logic [3:0] other;
                other = 4'(1 << ((s + 1) % 4));
                do_reset();
                unlock();
                wr(2'd1, {12'd0, other});
                wr(2'd2, {12'd0, 4'(1 << s)});
                wr(2'd3, 16'd200);
                if (p != 1) wr(2'd0, 16'h0F0F);
                if (p == 2) begin
                    fault_in = other;
                    @(negedge clk);
                    check("R9 setup alarm", irq, 1);
                end
                fault_in = fault_in | 4'(1 << s);
                @(negedge clk);
                check("R9 immediate pin_a", err_pin_a, 0);
                check("R9 immediate pin_b", err_pin_b, 0);
                check("R9 irq low in FAULT", irq, 0);
                fault_in = '0;
            end
        end

        // R10 parity injection on each register
        for (int a = 1; a < 4; a++) begin
            do_reset();
            unlock();
            wr(2'(a), (a == 3) ? 16'h8020 : 16'h8000);
            check("R10 still healthy at write", err_pin_a ^ err_pin_b, 1);
            @(negedge clk);
            check("R10 parity fault pin_a", err_pin_a, 0);
            check("R10 parity fault pin_b", err_pin_b, 0);
        end

        // R11 reaction supervisor window
        for (int c = 0; c < 5; c++) begin
            int k;
            k = done_at[c];
            setup(4'h0, 4'h1, 8'd0);
            fault_in = 4'h1;
            @(negedge clk);
            for (int j = 0; j < 70; j++) begin
                if (k < 0 && j == 63) check("R11 no reset at cycle 64", rst_req, 0);
                if (k < 0 && j == 64) check("R11 reset at cycle 65", rst_req, 1);
                react_done = (j == k);
                @(negedge clk);
            end
            react_done = 1'b0;
            check("R11 final rst_req", rst_req, (k < 0 || k >= 64) ? 1 : 0);
        end

        // R12 FAULT sticky against all writes
        unlock();
        wr(2'd1, 16'h000F);
        wr(2'd0, 16'h0F0F);
        wr(2'd0, 16'hC1EA);
        repeat (3) @(negedge clk);
        check("R12 pin_a static", err_pin_a, 0);
        check("R12 pin_b static", err_pin_b, 0);
        check("R12 irq low", irq, 0);
        check("R12 reset request held", rst_req, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule